// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Masking

This block watches the running time of a calendar clock and raises an alarm when it matches a programmed alarm time. The clock counter presents four BCD fields: seconds, minutes, hours and day-of-month. It also gives a one-cycle `sec_tick` strobe in the cycle where a new time value is presented. The alarm time has the same four fields. Each field has its own repeat bit. A field takes part in the comparison only while its repeat bit is 0. The set of cleared bits therefore sets the alarm period: every second, minute, hour, day or month.

A match is sampled only on a tick, and the time changes only on ticks. A given alarm setting therefore hits once per period and not on every system clock cycle. A hit sets a sticky flag. The flag stays set until software reads the flags register, which is shown to this block as the `flag_rd` strobe. An active-low interrupt line is driven low while the flag is set and the interrupt enable is 1.

Top module: `rtc_alarm_match`

## Requirements
- R1: While `rst` is high and in the cycle after it, `alarm_flag` is 0 and `irq_n` is 1.
- R2: With `repeat_bits` = 4'b1111, every `sec_tick` sets `alarm_flag` on the next clock edge, whatever the field values.
- R3: With `repeat_bits` = 4'b1110, only seconds (byte 0 of the time buses, bits 7:0) are compared. A tick sets the flag exactly when those bytes are equal.
- R4: With `repeat_bits` = 4'b1100, seconds and minutes (bits 15:8) must both be equal for a tick to set the flag.
- R5: With `repeat_bits` = 4'b1000, seconds, minutes and hours (bits 23:16) must all be equal.
- R6: With `repeat_bits` = 4'b0000, all four fields, including date (bits 31:24), must be equal. In general, field i is compared when `repeat_bits[i]` is 0.
- R7: Without `sec_tick` the flag is never set, even when all compared fields are equal.
- R8: Once set, `alarm_flag` stays 1 until a `flag_rd` pulse. That pulse clears it on the next edge.
- R9: When a tick hit and `flag_rd` fall in the same cycle, the flag ends up 1.
- R10: `irq_n` is 0 exactly when `alarm_flag` is 1 and `alarm_irq_en` is 1. Otherwise it is 1.
- R11: The comparison is an exact 8-bit equality per field. A difference in any single bit of a compared field, including codes that are not valid BCD, prevents a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe: a new time value is presented |
| time_now | input | 32 | Current time {date, hours, minutes, seconds}, BCD |
| time_alarm | input | 32 | Alarm time, same layout |
| repeat_bits | input | 4 | Per-field mask; bit i = 1 drops field i from the compare |
| alarm_irq_en | input | 1 | Enables the interrupt output |
| flag_rd | input | 1 | Flags-register read strobe; clears the flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Each of the five repeat patterns gets times equal to the alarm, times that differ in exactly one field, and times that differ in a single bit. This shows whether a given field is truly compared or truly masked. Ticked and unticked cycles with matching fields separate sampling on the tick from level matching. Reads alone and reads coinciding with a hit check the clear rule and its priority. Toggling the enable while the flag is held separates the interrupt gating from the flag itself. Random masks, including ones outside the five standard patterns, test the per-field rule.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    parameter int FIELD_W    = 8;
    parameter int NUM_FIELDS = 4;
    localparam int TIME_W    = FIELD_W * NUM_FIELDS;

    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } field_e;

    typedef enum logic [NUM_FIELDS-1:0] {
        PER_SECOND = 4'b1111,
        PER_MINUTE = 4'b1110,
        PER_HOUR   = 4'b1100,
        PER_DAY    = 4'b1000,
        PER_MONTH  = 4'b0000
    } period_e;

    typedef struct packed {
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] minute;
        logic [FIELD_W-1:0] second;
    } stamp_t;

    // Fields that take part in the compare: those whose repeat bit is clear.
    function automatic logic [NUM_FIELDS-1:0] compare_mask(input logic [NUM_FIELDS-1:0] rpt);
        return ~rpt;
    endfunction

    function automatic stamp_t to_stamp(input logic [TIME_W-1:0] v);
        return stamp_t'(v);
    endfunction

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int NF = NUM_FIELDS,
    localparam int TW = FW * NF
) (
    input  logic [TW-1:0] now_v,
    input  logic [TW-1:0] alm_v,
    input  logic [NF-1:0] rpt,
    output logic          hit
);
    logic [NF-1:0] cmp_en;
    logic [NF-1:0] fld_ok;

    assign cmp_en = ~rpt;

    for (genvar i = 0; i < NF; i++) begin : g_field
        logic eq;
        assign eq        = (now_v[i*FW +: FW] == alm_v[i*FW +: FW]);
        assign fld_ok[i] = !cmp_en[i] || eq;
    end

    assign hit = &fld_ok;
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_req) flag <= 1'b1;   // a new hit outranks a read
        else if (clr_req) flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
    input  logic flag,
    input  logic enable,
    output logic req_n
);
    always_comb begin
        req_n = 1'b1;
        if (flag && enable) req_n = 1'b0;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int NF = NUM_FIELDS,
    localparam int TW = FW * NF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sec_tick,
    input  logic [TW-1:0] time_now,
    input  logic [TW-1:0] time_alarm,
    input  logic [NF-1:0] repeat_bits,
    input  logic          alarm_irq_en,
    input  logic          flag_rd,
    output logic          alarm_flag,
    output logic          irq_n
);
    logic fields_hit;
    logic hit_now;

    rtc_alarm_cmp #(.FW(FW), .NF(NF)) u_cmp (
        .now_v (time_now),
        .alm_v (time_alarm),
        .rpt   (repeat_bits),
        .hit   (fields_hit)
    );

    // Sample the compare only when the counter presents a new time.
    assign hit_now = sec_tick && fields_hit;

    rtc_alarm_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (hit_now),
        .clr_req (flag_rd),
        .flag    (alarm_flag)
    );

    rtc_alarm_irq u_irq (
        .flag   (alarm_flag),
        .enable (alarm_irq_en),
        .req_n  (irq_n)
    );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
    parameter int FW = 8,
    parameter int NF = 4,
    localparam int TW = FW * NF
) (
    input logic          clk,
    input logic          rst,
    input logic          sec_tick,
    input logic [TW-1:0] time_now,
    input logic [TW-1:0] time_alarm,
    input logic [NF-1:0] repeat_bits,
    input logic          alarm_irq_en,
    input logic          flag_rd,
    input logic          alarm_flag,
    input logic          irq_n
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!alarm_flag && irq_n));

    a_r2_every_tick: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && (&repeat_bits)) |=> alarm_flag);

    a_r3_sec_mismatch: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !repeat_bits[0] && (time_now[FW-1:0] != time_alarm[FW-1:0]) && !alarm_flag)
        |=> !alarm_flag);

    a_r7_no_set_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !alarm_flag) |=> !alarm_flag);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !flag_rd) |=> alarm_flag);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && !sec_tick) |=> !alarm_flag);

    a_r10_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !alarm_irq_en |-> irq_n);

    a_r10_no_flag_idle: assert property (@(posedge clk) disable iff (rst)
        !alarm_flag |-> irq_n);
endmodule

bind rtc_alarm_match rtc_alarm_chk #(.FW(FW), .NF(NF)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sec_tick     (sec_tick),
    .time_now     (time_now),
    .time_alarm   (time_alarm),
    .repeat_bits  (repeat_bits),
    .alarm_irq_en (alarm_irq_en),
    .flag_rd      (flag_rd),
    .alarm_flag   (alarm_flag),
    .irq_n        (irq_n)
);

// File: tb/sim_rtc_alarm_match.sv
`timescale 1ns/1ps
module sim_rtc_alarm_match;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic [31:0] time_now = '0;
    logic [31:0] time_alarm = '0;
    logic [3:0]  repeat_bits = 4'hF;
    logic        alarm_irq_en = 1'b0;
    logic        flag_rd = 1'b0;
    logic        alarm_flag;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    logic mflag = 1'b0;

    always #2 clk = ~clk;

    rtc_alarm_match u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .time_now(time_now),
        .time_alarm(time_alarm), .repeat_bits(repeat_bits),
        .alarm_irq_en(alarm_irq_en), .flag_rd(flag_rd),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    function automatic logic exp_hit(input logic [3:0] rpt, input logic [31:0] a, input logic [31:0] b);
        logic ok = 1'b1;
        for (int i = 0; i < 4; i++)
            if (!rpt[i] && (a[i*8 +: 8] != b[i*8 +: 8])) ok = 1'b0;
        return ok;
    endfunction

    function automatic string tag_of(input logic [3:0] rpt);
        case (rpt)
            4'b1111: return "R2";
            4'b1110: return "R3";
            4'b1100: return "R4";
            4'b1000: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic step(input logic tk, input logic rd);
        sec_tick = tk;
        flag_rd  = rd;
        @(posedge clk);
        if (rst)                                         mflag = 1'b0;
        else if (tk && exp_hit(repeat_bits, time_now, time_alarm)) mflag = 1'b1;
        else if (rd)                                     mflag = 1'b0;
        #1;
        sec_tick = 1'b0;
        flag_rd  = 1'b0;
    endtask

    task automatic check(input string req);
        logic exp_irq;
        exp_irq = !(mflag && alarm_irq_en);
        n_tests++;
        if (alarm_flag !== mflag || irq_n !== exp_irq) begin
            n_fail++;
            $display("FAIL %s: flag=%0b irq_n=%0b expected flag=%0b irq_n=%0b",
                     req, alarm_flag, irq_n, mflag, exp_irq);
        end
    endtask

    task automatic clear_flag();
        step(1'b0, 1'b1);
    endtask

    // Directed: one field differing or matching for a given mask.
    task automatic try_pattern(input logic [3:0] rpt, input logic [31:0] now_v, input string req);
        clear_flag();
        repeat_bits = rpt;
        time_now    = now_v;
        step(1'b1, 1'b0);
        check(req);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] base;
        void'($urandom(32'd1234));
        base = 32'h15_23_47_59;
        time_alarm = base;
        alarm_irq_en = 1'b1;

        step(1'b0, 1'b0);
        check("R1");
        step(1'b1, 1'b0);   // tick while still in reset
        check("R1");
        rst = 1'b0;
        step(1'b0, 1'b0);
        check("R1");

        // R2: every tick with everything masked
        try_pattern(4'b1111, 32'h01_02_03_04, "R2");
        // R3: seconds only
        try_pattern(4'b1110, {8'h00, 8'h00, 8'h00, 8'h59}, "R3");
        try_pattern(4'b1110, {8'h15, 8'h23, 8'h47, 8'h58}, "R3");
        // R4
        try_pattern(4'b1100, {8'h00, 8'h00, 8'h47, 8'h59}, "R4");
        try_pattern(4'b1100, {8'h15, 8'h23, 8'h46, 8'h59}, "R4");
        // R5
        try_pattern(4'b1000, {8'h01, 8'h23, 8'h47, 8'h59}, "R5");
        try_pattern(4'b1000, {8'h15, 8'h22, 8'h47, 8'h59}, "R5");
        // R6
        try_pattern(4'b0000, base, "R6");
        try_pattern(4'b0000, {8'h14, 8'h23, 8'h47, 8'h59}, "R6");
        try_pattern(4'b0101, {8'h15, 8'h00, 8'h47, 8'h00}, "R6");
        // R11: single-bit and non-BCD differences
        for (int b = 0; b < 32; b++)
            try_pattern(4'b0000, base ^ (32'h1 << b), "R11");
        time_alarm = 32'hFA_BC_DE_AF;
        try_pattern(4'b0000, 32'hFA_BC_DE_AF, "R11");
        time_alarm = base;

        // R7: match without tick
        clear_flag();
        repeat_bits = 4'b0000;
        time_now = base;
        repeat (3) begin step(1'b0, 1'b0); check("R7"); end

        // R8: sticky and read clear
        step(1'b1, 1'b0);
        check("R8");
        time_now = 32'h0;
        repeat (3) begin step(1'b1, 1'b0); check("R8"); end
        step(1'b0, 1'b1);
        check("R8");

        // R9: hit and read together
        time_now = base;
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check("R9");

        // R10: enable gating while flag held
        alarm_irq_en = 1'b0;
        step(1'b0, 1'b0);
        check("R10");
        alarm_irq_en = 1'b1;
        #0.5;
        check("R10");
        clear_flag();
        check("R10");

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [3:0] r;
            case ($urandom_range(0, 5))
                0: r = 4'b1111;
                1: r = 4'b1110;
                2: r = 4'b1100;
                3: r = 4'b1000;
                4: r = 4'b0000;
                default: r = 4'($urandom);
            endcase
            repeat_bits = r;
            time_alarm = $urandom;
            time_now = time_alarm;
            for (int f = 0; f < 4; f++)
                if ($urandom_range(0, 3) == 0) time_now[f*8 +: 8] = 8'($urandom);
            alarm_irq_en = 1'($urandom);
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) == 0));
            check(tag_of(r));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule